// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between a CPU's 16-bit address bus and the memories and register files of a small system. For every address it raises exactly one region select and produces the physical offset into that region, so that the memories themselves only need to index with the offset. The regions are the start-up ROM, the cartridge space, video RAM, work RAM, object attribute RAM, the I/O register page, high RAM and the interrupt-enable register.

Two pieces of state live here. The first is a work-RAM bank register, which picks the page seen in the upper 4 KiB window of work RAM and its mirror. The second is a one-way latch that removes the start-up ROM overlay. A color-mode input turns on bank switching and a second overlay window. The block also answers CPU reads of the bank register, and returns 0xFF for I/O addresses that no other register file claims. Address decode is combinational. State changes happen on the clock edge that samples a write strobe.

Top module: `mem_addr_decoder`

## Requirements
- R1: `region_o` is always one-hot, with bit 0 start-up ROM, bit 1 cartridge, bit 2 video RAM, bit 3 work RAM, bit 4 object RAM, bit 5 I/O, bit 6 high RAM and bit 7 interrupt enable. Priority from highest to lowest: 0xFFFF interrupt enable, 0xFF80–0xFFFE high RAM, 0xFF00–0xFF7F I/O, 0xFE00–0xFEFF object RAM, 0xC000–0xFDFF work RAM, 0xA000–0xBFFF cartridge, 0x8000–0x9FFF video RAM, start-up ROM overlay, and cartridge for everything else.
- R2: 0xC000–0xCFFF and its mirror 0xE000–0xEFFF give a work-RAM offset of addr[11:0] (page 0).
- R3: 0xD000–0xDFFF and its mirror 0xF000–0xFDFF give offset eff_bank×0x1000 + addr[11:0]. eff_bank is the stored bank in color mode, with a stored 0 replaced by 1. Outside color mode eff_bank is always 1.
- R4: A write strobe to 0xFF70 in color mode stores wdata AND 0x07 at the next clock edge. The same write outside color mode leaves the stored bank unchanged.
- R5: Reading 0xFF70 raises `local_hit_o`. `local_data_o` is stored bank OR 0xF8 in color mode and 0xFF otherwise.
- R6: While the overlay is enabled, 0x0000–0x00FF select the start-up ROM. In color mode 0x0200–0x08FF also select it. 0x0100–0x01FF stay cartridge. The offset is the address itself.
- R7: A write to 0xFF50 with bit 0 set disables the overlay from the next clock edge. A write with bit 0 clear has no effect. Once disabled, the overlay never comes back until reset.
- R8: `wr_en_o` follows `wr_i` except when the start-up ROM is selected, where it is 0.
- R9: The offsets are as follows. Video RAM: addr−0x8000. Object RAM and I/O: addr[7:0]. High RAM: addr AND 0x7F. Interrupt enable: 0. Cartridge: the address itself.
- R10: In 0xFF00–0xFF7F the following are claimed by other blocks and give `local_hit_o`=0: low bytes 0x00–0x4B, plus, in color mode only, 0x4D, 0x4F, 0x51–0x56, 0x68–0x6B and 0x72–0x77. Every other I/O address except 0xFF70 gives `local_hit_o`=1 with data 0xFF. Outside the I/O page `local_hit_o` is 0.
- R11: After reset the stored bank is 1 and the overlay is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| color_mode_i | input | 1 | Enables banking and the second overlay window |
| addr_i | input | 16 | CPU address |
| wr_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| region_o | output | 8 | One-hot region select |
| offset_o | output | 16 | Physical offset in the selected region |
| wr_en_o | output | 1 | Write strobe passed to the selected region |
| local_hit_o | output | 1 | Read answered by this block |
| local_data_o | output | 8 | Read data for a local hit |

## Verification
The full 64 Ki address space is swept under six states. These cover color mode on and off, the overlay enabled and disabled, and stored banks of 1, 0 and 5. Each state separates a different mechanism. The stored-0 sweep catches a missing zero-to-one substitution. The bank-5 sweep catches wrong offset scaling or a missing mirror. The color-off sweeps catch banking or the second overlay window leaking outside color mode. The overlay-off sweeps check that the cartridge region reappears underneath. Targeted write sequences check the one-edge latency of bank and latch updates, writes that must be ignored, and the gating of the write strobe over the ROM.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int REGION_N = 8;
  localparam int WIN_W    = 12;

  localparam int RG_BOOT = 0;
  localparam int RG_CART = 1;
  localparam int RG_VRAM = 2;
  localparam int RG_WRAM = 3;
  localparam int RG_OAM  = 4;
  localparam int RG_IO   = 5;
  localparam int RG_HRAM = 6;
  localparam int RG_IE   = 7;

  typedef logic [REGION_N-1:0] region_t;

  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 16'hFF70;
  localparam logic [ADDR_W-1:0] BOOT_OFF_ADDR = 16'hFF50;
  localparam logic [7:0]        IO_BASE_LAST  = 8'h4B;
  localparam logic [DATA_W-1:0] OPEN_BUS      = 8'hFF;

  // I/O low-byte ranges owned by color-only register files
  localparam int CLR_N = 5;
  localparam logic [CLR_N-1:0][7:0] CLR_LO = {8'h72, 8'h68, 8'h51, 8'h4F, 8'h4D};
  localparam logic [CLR_N-1:0][7:0] CLR_HI = {8'h77, 8'h6B, 8'h56, 8'h4F, 8'h4D};
endpackage

// File: rtl/mem_dec_ctrl_regs.sv
module mem_dec_ctrl_regs
  import mem_dec_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int BANK_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              color_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [BANK_W-1:0] eff_bank_o,
  output logic              boot_en_o
);
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [BANK_W-1:0] bank_q;
  logic              boot_off_q;
  logic              bank_we, boot_kill;

  assign bank_we   = wr_i && color_mode_i && (addr_i == BANK_REG_ADDR);
  assign boot_kill = wr_i && (addr_i == BOOT_OFF_ADDR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= BANK_W'(BANK_RST);
      boot_off_q <= 1'b0;
    end else begin
      if (bank_we)   bank_q     <= wdata_i[BANK_W-1:0];
      if (boot_kill) boot_off_q <= 1'b1;
    end
  end

  always_comb begin
    if (!color_mode_i || bank_q == '0) eff_bank_o = BANK_ONE;
    else                               eff_bank_o = bank_q;
  end

  assign bank_o    = bank_q;
  assign boot_en_o = !boot_off_q;

  // R4: bank changes only through a color-mode write to its address
  a_r4_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && color_mode_i && addr_i == BANK_REG_ADDR) |=> $stable(bank_q));
  a_r4_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && color_mode_i && addr_i == BANK_REG_ADDR) |=> bank_q == $past(wdata_i[BANK_W-1:0]));
  // R7: latch is one-way; clear-bit writes do nothing
  a_r7_latch_oneway: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_off_q |=> boot_off_q);
  a_r7_clear_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_off_q && !(wr_i && addr_i == BOOT_OFF_ADDR && wdata_i[0])) |=> !boot_off_q);
endmodule

// File: rtl/mem_dec_region.sv
module mem_dec_region
  import mem_dec_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              color_mode_i,
  input  logic              boot_en_i,
  input  logic [BANK_W-1:0] eff_bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output region_t           region_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic              boot_hit;
  logic [BANK_W-1:0] page;

  assign boot_hit = boot_en_i &&
                    ((addr_i[15:8] == 8'h00) ||
                     (color_mode_i && addr_i >= 16'h0200 && addr_i <= 16'h08FF));
  assign page = addr_i[WIN_W] ? eff_bank_i : '0;

  always_comb begin
    region_o = '0;
    offset_o = addr_i;
    if (addr_i == 16'hFFFF) begin
      region_o[RG_IE] = 1'b1;
      offset_o        = '0;
    end else if (addr_i[15:7] == 9'h1FF) begin
      region_o[RG_HRAM] = 1'b1;
      offset_o          = {9'b0, addr_i[6:0]};
    end else if (addr_i[15:8] == 8'hFF) begin
      region_o[RG_IO] = 1'b1;
      offset_o        = {8'b0, addr_i[7:0]};
    end else if (addr_i[15:8] == 8'hFE) begin
      region_o[RG_OAM] = 1'b1;
      offset_o         = {8'b0, addr_i[7:0]};
    end else if (addr_i[15:14] == 2'b11) begin
      region_o[RG_WRAM] = 1'b1;
      offset_o          = (ADDR_W'(page) << WIN_W) | ADDR_W'(addr_i[WIN_W-1:0]);
    end else if (addr_i[15:13] == 3'b101) begin
      region_o[RG_CART] = 1'b1;
    end else if (addr_i[15:13] == 3'b100) begin
      region_o[RG_VRAM] = 1'b1;
      offset_o          = {3'b0, addr_i[12:0]};
    end else if (boot_hit) begin
      region_o[RG_BOOT] = 1'b1;
    end else begin
      region_o[RG_CART] = 1'b1;
    end
  end
endmodule

// File: rtl/mem_dec_io_read.sv
module mem_dec_io_read
  import mem_dec_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              color_mode_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              local_hit_o,
  output logic [DATA_W-1:0] local_data_o
);
  logic [7:0]       lo;
  logic             in_io;
  logic [CLR_N-1:0] clr_hit;
  logic             claimed;

  assign lo    = addr_i[7:0];
  assign in_io = (addr_i[15:7] == 9'h1FE);

  for (genvar g = 0; g < CLR_N; g++) begin : g_clr
    assign clr_hit[g] = (lo >= CLR_LO[g]) && (lo <= CLR_HI[g]);
  end

  assign claimed = (lo <= IO_BASE_LAST) || (color_mode_i && |clr_hit);

  always_comb begin
    local_hit_o  = 1'b0;
    local_data_o = OPEN_BUS;
    if (addr_i == BANK_REG_ADDR) begin
      local_hit_o = 1'b1;
      if (color_mode_i)
        local_data_o = {{(DATA_W-BANK_W){1'b1}}, bank_i};
    end else if (in_io && !claimed) begin
      local_hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
  import mem_dec_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int BANK_RST = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        color_mode_i,
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  region_o,
  output logic [15:0] offset_o,
  output logic        wr_en_o,
  output logic        local_hit_o,
  output logic [7:0]  local_data_o
);
  logic [BANK_W-1:0] bank, eff_bank;
  logic              boot_en;
  region_t           region;

  mem_dec_ctrl_regs #(.BANK_W(BANK_W), .BANK_RST(BANK_RST)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .color_mode_i(color_mode_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .bank_o      (bank),
    .eff_bank_o  (eff_bank),
    .boot_en_o   (boot_en)
  );

  mem_dec_region #(.BANK_W(BANK_W)) u_region (
    .color_mode_i(color_mode_i),
    .boot_en_i   (boot_en),
    .eff_bank_i  (eff_bank),
    .addr_i      (addr_i),
    .region_o    (region),
    .offset_o    (offset_o)
  );

  mem_dec_io_read #(.BANK_W(BANK_W)) u_io (
    .color_mode_i(color_mode_i),
    .bank_i      (bank),
    .addr_i      (addr_i),
    .local_hit_o (local_hit_o),
    .local_data_o(local_data_o)
  );

  assign region_o = region;
  assign wr_en_o  = wr_i && !region[RG_BOOT];

  // R1: exactly one region at a time
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(region_o));
  // R8: no write reaches the start-up ROM
  a_r8_boot_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_o[RG_BOOT] |-> !wr_en_o);
  // R6: overlay gone once latch fires
  a_r6_boot_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_en |-> !region_o[RG_BOOT]);
  // R3: upper work-RAM window never lands on page 0
  a_r3_upper_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o[RG_WRAM] && addr_i[WIN_W]) |-> (offset_o[ADDR_W-1:WIN_W] != '0));
  // R10: local answers only inside the I/O page
  a_r10_local_in_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_hit_o |-> region_o[RG_IO]);
endmodule

// File: tb/mem_addr_decoder_tb.sv
module mem_addr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        color_mode_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  region_o;
  logic [15:0] offset_o;
  logic        wr_en_o;
  logic        local_hit_o;
  logic [7:0]  local_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mem_addr_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .color_mode_i(color_mode_i),
    .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .region_o(region_o), .offset_o(offset_o), .wr_en_o(wr_en_o),
    .local_hit_o(local_hit_o), .local_data_o(local_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr_i, act, exp);
    end
  endtask

  function automatic int exp_region(int a, bit color, bit boot_en);
    if (a == 16'hFFFF) return 7;
    if (a >= 16'hFF80) return 6;
    if (a >= 16'hFF00) return 5;
    if (a >= 16'hFE00) return 4;
    if (a >= 16'hC000) return 3;
    if (a >= 16'hA000) return 1;
    if (a >= 16'h8000) return 2;
    if (boot_en && a < 16'h0100) return 0;
    if (boot_en && color && a >= 16'h0200 && a <= 16'h08FF) return 0;
    return 1;
  endfunction

  function automatic int exp_offset(int a, int rg, int eff);
    case (rg)
      7: return 0;
      6: return a % 128;
      5, 4: return a % 256;
      3: return ((a / 4096) % 2 == 1 ? eff * 4096 : 0) + (a % 4096);
      2: return a - 16'h8000;
      default: return a;
    endcase
  endfunction

  function automatic bit exp_hit(int a, bit color);
    int lo;
    if (a < 16'hFF00 || a > 16'hFF7F) return 1'b0;
    lo = a % 256;
    if (lo == 16'h70) return 1'b1;
    if (lo <= 16'h4B) return 1'b0;
    if (color && (lo == 16'h4D || lo == 16'h4F || (lo >= 16'h51 && lo <= 16'h56) ||
                  (lo >= 16'h68 && lo <= 16'h6B) || (lo >= 16'h72 && lo <= 16'h77)))
      return 1'b0;
    return 1'b1;
  endfunction

  // full address sweep; wr_i held low so no state moves
  task automatic sweep(input bit boot_en, input int stored, input string tag);
    int eff;
    eff = (color_mode_i && stored != 0) ? stored : 1;
    for (int a = 0; a < 65536; a++) begin
      int rg, off, ed;
      bit eh;
      addr_i = 16'(a);
      #1;
      rg  = exp_region(a, color_mode_i, boot_en);
      off = exp_offset(a, rg, eff);
      eh  = exp_hit(a, color_mode_i);
      ed  = (a == 16'hFF70 && color_mode_i) ? (stored + 16'hF8) : 16'hFF;
      // R1 R2 R3 R6 R9 region and offset
      chk(region_o == 8'(1 << rg), {tag, " R1 region"}, region_o, 1 << rg);
      if (region_o == 8'(1 << rg))
        chk(offset_o == 16'(off), {tag, " R2/R3/R6/R9 offset"}, offset_o, off);
      // R10 R5 local read answers
      chk(local_hit_o == eh, {tag, " R10 local_hit"}, local_hit_o, eh);
      if (eh) chk(local_data_o == 8'(ed), {tag, " R5 R10 local_data"}, local_data_o, ed);
      chk(wr_en_o == 1'b0, {tag, " R8 idle wr_en"}, wr_en_o, 0);
    end
  endtask

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wr_en_probe(input logic [15:0] a, input bit exp, input string tag);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b1;
    #1;
    chk(wr_en_o == exp, tag, wr_en_o, exp);
    wr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    addr_i = 16'hFF70; #1;
    chk(local_data_o == 8'hF9, "R11 reset bank", local_data_o, 8'hF9);
    addr_i = 16'h0000; #1;
    chk(region_o == 8'h01, "R11 overlay on", region_o, 8'h01);

    sweep(1'b1, 1, "S1");

    // R4 one-edge latency, stored 0
    @(negedge clk_i);
    addr_i = 16'hFF70; wdata_i = 8'hF8; wr_i = 1'b1; #1;
    chk(local_data_o == 8'hF9, "R4 old bank before edge", local_data_o, 8'hF9);
    @(negedge clk_i);
    wr_i = 1'b0; #1;
    chk(local_data_o == 8'hF8, "R4 bank after edge", local_data_o, 8'hF8);
    sweep(1'b1, 0, "S2");

    wr_cycle(16'hFF70, 8'h0D);
    sweep(1'b1, 5, "S3");

    // R4 write ignored outside color mode
    color_mode_i = 1'b0;
    wr_cycle(16'hFF70, 8'h02);
    sweep(1'b1, 5, "S4");

    // R8 strobe gating with overlay
    wr_en_probe(16'h0050, 1'b0, "R8 boot write blocked");
    wr_en_probe(16'h0150, 1'b1, "R8 cart write passes");
    wr_en_probe(16'hC123, 1'b1, "R8 wram write passes");

    // R7 clear-bit write ignored
    wr_cycle(16'hFF50, 8'hFE);
    addr_i = 16'h0010; #1;
    chk(region_o == 8'h01, "R7 clear-bit ignored", region_o, 8'h01);
    wr_cycle(16'hFF50, 8'h01);
    addr_i = 16'h0010; #1;
    chk(region_o == 8'h02, "R7 overlay disabled", region_o, 8'h02);
    wr_cycle(16'hFF50, 8'h00);
    addr_i = 16'h0010; #1;
    chk(region_o == 8'h02, "R7 no re-enable", region_o, 8'h02);
    wr_en_probe(16'h0050, 1'b1, "R8 write after overlay off");

    color_mode_i = 1'b1;
    addr_i = 16'hFF70; #1;
    chk(local_data_o == 8'hFD, "R4 bank kept through non-color write", local_data_o, 8'hFD);
    sweep(1'b0, 5, "S5");
    color_mode_i = 1'b0;
    sweep(1'b0, 5, "S6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule